// File: doc/BRIEF.md
# Fixed-Point First-Order Recursive Filter

This block computes a one-pole recursive filter on a stream of 16-bit signed samples: each new output is the previous output scaled by a coefficient near 0.9, plus the new input sample. All arithmetic is plain integer arithmetic on fixed binary-point formats. The input sample is a pure fraction with no integer bits. The output and the filter state carry four integer bits. The coefficient is a pure fraction as well.

To keep every operand on a common binary point, the product of coefficient and state keeps only its upper 16 bits, which places it in a format with five integer bits. The input is arithmetically shifted right by five places so that it adds in that same format. The sum is then doubled, which drops the redundant second sign bit and returns to the four-integer-bit output format. The doubling step can optionally clamp to the extreme 16-bit codes when the doubled value does not fit.

A sample is offered with a valid strobe. Exactly one result comes back per accepted sample, qualified by its own strobe, one clock later. The result register is also the filter state.

Top module: `iir_fx1`

## Requirements
- R1: A synchronous active-high reset clears the filter state and the output sample to 0 and drives the output strobe low in the cycle after the reset edge.
- R2: The output strobe is high in exactly the cycle after an input sample is accepted (input strobe high at a rising edge) and low after every edge with the input strobe low.
- R3: The product term is the upper 16 bits of the full 32-bit signed product of the coefficient code (default 29491) and the current state. This is the floor of product divided by 65536.
- R4: The input sample is arithmetically shifted right by 5 places (rounding toward minus infinity) before it is added to the product term, so an input of -1 from a zero state yields -2.
- R5: The new output is twice the sum of product term and shifted input. The state takes that new output value for the next sample.
- R6: A cycle with the input strobe low leaves the output sample and the state unchanged.
- R7: With saturation selected, a doubled sum above 32767 gives 0x7FFF and one below -32768 gives 0x8000. The state takes the clamped value.
- R8: With wrapping selected, the output keeps the low 16 bits of the doubled sum in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | 16 | Signed input sample, no integer bits |
| out_valid | output | 1 | Output sample strobe |
| out_y | output | 16 | Signed output sample, four integer bits |

## Verification
Because the output register is the filter state, any wrong state value reaches the port in the same cycle. It also corrupts every later sample through the recursion, so a single mis-scaled product or mis-aligned input shows up within one accepted sample and keeps diverging. A fault in the clamp or wrap path stays hidden under the default coefficient, whose sums never overflow. The bench therefore also runs copies of the block with a coefficient near one, which drive the state into both rails within a few samples of a full-scale input.

// File: rtl/iir_fx_pkg.sv
package iir_fx_pkg;
  typedef enum logic {OVF_WRAP = 1'b0, OVF_SAT = 1'b1} ovf_mode_e;
  localparam int DEF_W      = 16;
  localparam int DEF_COEF   = 29491;
  localparam int DEF_XSHIFT = 5;
endpackage

// File: rtl/iir_mul_hi.sv
module iir_mul_hi #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] state,
  output logic signed [W-1:0] hi
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] prod;

  always_comb begin
    prod = coef * state;
    hi   = prod[PW-1:W];
  end

  // R3
  always_comb begin
    if (state == '0) begin
      zero_state_prod_chk: assert (hi == '0);
    end
  end
endmodule

// File: rtl/iir_align_add.sv
module iir_align_add #(
  parameter int W      = 16,
  parameter int XSHIFT = 5
) (
  input  logic signed [W-1:0] hi,
  input  logic signed [W-1:0] x,
  output logic signed [W:0]   sum
);
  logic signed [W-1:0] xa;

  always_comb begin
    xa  = x >>> XSHIFT;
    sum = {hi[W-1], hi} + {xa[W-1], xa};
  end

  // R4
  always_comb begin
    align_sign_chk: assert (xa[W-1] == x[W-1]);
  end
endmodule

// File: rtl/iir_renorm.sv
module iir_renorm
  import iir_fx_pkg::*;
#(
  parameter int        W    = 16,
  parameter ovf_mode_e MODE = OVF_SAT
) (
  input  logic signed [W:0]   sum,
  output logic signed [W-1:0] y,
  output logic                ovf
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  logic signed [W+1:0] full;

  always_comb begin
    full = {sum, 1'b0};
    ovf  = !((full[W+1:W-1] == 3'b000) || (full[W+1:W-1] == 3'b111));
  end

  generate
    if (MODE == OVF_SAT) begin : g_sat
      always_comb begin
        if (ovf) y = sum[W] ? MINV : MAXV;
        else     y = full[W-1:0];
      end
      // R7
      always_comb begin
        if (ovf) begin
          clamp_rail_chk: assert ((y == MAXV && !sum[W]) || (y == MINV && sum[W]));
        end
      end
    end else begin : g_wrap
      always_comb y = full[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/iir_fx1.sv
module iir_fx1
  import iir_fx_pkg::*;
#(
  parameter int        W        = DEF_W,
  parameter int        COEF     = DEF_COEF,
  parameter int        XSHIFT   = DEF_XSHIFT,
  parameter ovf_mode_e OVF_MODE = OVF_SAT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  output logic                out_valid,
  output logic signed [W-1:0] out_y
);
  localparam logic signed [W-1:0] COEF_V = W'(COEF);

  logic signed [W-1:0] y_q;
  logic                v_q;
  logic signed [W-1:0] prod_hi;
  logic signed [W:0]   sum_w;
  logic signed [W-1:0] y_next;
  logic                ovf_w;

  iir_mul_hi #(.W(W)) u_mul (
    .coef  (COEF_V),
    .state (y_q),
    .hi    (prod_hi)
  );

  iir_align_add #(.W(W), .XSHIFT(XSHIFT)) u_add (
    .hi  (prod_hi),
    .x   (in_x),
    .sum (sum_w)
  );

  iir_renorm #(.W(W), .MODE(OVF_MODE)) u_norm (
    .sum (sum_w),
    .y   (y_next),
    .ovf (ovf_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) y_q <= y_next;
    end
  end

  assign out_valid = v_q;
  assign out_y     = y_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (out_y == '0 && !out_valid));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_y));
endmodule

// File: tb/iir_fx1_tb.sv
`timescale 1ns/1ps
module iir_fx1_tb;
  import iir_fx_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_x = '0;
  logic v0, v1, v2;
  logic signed [15:0] y0, y1, y2;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m0, m1, m2;

  always #4 clk = ~clk;

  iir_fx1 u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
                 .out_valid(v0), .out_y(y0));
  iir_fx1 #(.COEF(32767), .OVF_MODE(OVF_SAT)) u_dut_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v1), .out_y(y1));
  iir_fx1 #(.COEF(32767), .OVF_MODE(OVF_WRAP)) u_dut_wrap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v2), .out_y(y2));

  function automatic int model(input int coef, input int s, input int x,
                               input bit sat, output bit ovf);
    longint p, hi, xa, full;
    int r;
    p    = longint'(coef) * longint'(s);
    hi   = p >>> 16;
    xa   = longint'(x) >>> 5;
    full = (hi + xa) * 2;
    ovf  = (full > 32767) || (full < -32768);
    if (!ovf) r = int'(full);
    else if (sat) r = (full > 0) ? 32767 : -32768;
    else r = int'($signed(16'(full)));
    return r;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input int xv, input string tag);
    bit o0, o1, o2;
    int e0, e1, e2;
    @(negedge clk);
    in_valid = v;
    in_x = 16'(xv);
    e0 = m0; e1 = m1; e2 = m2;
    o0 = 0; o1 = 0; o2 = 0;
    if (v) begin
      e0 = model(29491, m0, xv, 1'b1, o0);
      e1 = model(32767, m1, xv, 1'b1, o1);
      e2 = model(32767, m2, xv, 1'b0, o2);
    end
    @(posedge clk);
    #2;
    m0 = e0; m1 = e1; m2 = e2;
    chk("R2 valid", int'(v0), int'(v));
    chk("R2 valid", int'(v1), int'(v));
    chk("R2 valid", int'(v2), int'(v));
    chk(v ? tag : "R6 hold", int'(y0), e0);
    chk(!v ? "R6 hold" : (o1 ? "R7 clamp" : tag), int'(y1), e1);
    chk(!v ? "R6 hold" : (o2 ? "R8 wrap" : tag), int'(y2), e2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    m0 = 0; m1 = 0; m2 = 0;
    chk("R1 reset y", int'(y0), 0);
    chk("R1 reset y", int'(y1), 0);
    chk("R1 reset y", int'(y2), 0);
    chk("R1 reset valid", int'(v0 | v1 | v2), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m0 = 0; m1 = 0; m2 = 0;
    repeat (2) @(posedge clk);
    do_reset();
    // R4: -1 from zero state gives -2
    step(1'b1, -1, "R4 align");
    do_reset();
    step(1'b1, 16384, "R4 align");
    // R3: zero input exposes product term alone
    step(1'b1, 0, "R3 product");
    step(1'b1, 0, "R3 product");
    step(1'b0, 0, "R6 hold");
    step(1'b0, 32767, "R6 hold");
    // drive toward the positive rail
    for (int i = 0; i < 25; i++) step(1'b1, 32767, "R5 recursion");
    // and toward the negative rail
    for (int i = 0; i < 40; i++) step(1'b1, -32768, "R5 recursion");
    do_reset();
    for (int i = 0; i < 600; i++) begin
      bit v;
      int xv;
      v  = ($urandom % 4) != 0;
      xv = int'($signed(16'($urandom)));
      if (($urandom % 8) == 0) xv = (($urandom % 2) != 0) ? 32767 : -32768;
      step(v, xv, "R5 recursion");
      if (i == 300) do_reset();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule